// File: doc/BRIEF.md
# DMA Stream Word Buffer with Fill Threshold

This block is the small per-channel data buffer that sits inside a DMA stream, between the side that reads from the source and the side that writes to the destination. Both sides use a valid/ready word handshake. In buffered mode the block collects source words in a four-entry store. It offers nothing to the destination until the stored count reaches a programmable quarter-step threshold. It then hands over exactly that many words as one burst and waits for the threshold again. In direct mode the store is skipped: each source word goes straight through to the destination, and the source handshake is tied to the destination handshake in the same cycle.

A flush input ends a transfer. It pushes out whatever words remain below the threshold and raises a one-cycle done pulse once the store is empty. The block flags a buffer error when the source presents a word while the store is full. The flag is sticky and is cleared by a write-one-to-clear input. It reaches the interrupt output only when the channel's error enable is set. Mode, threshold and enable are loaded through a configuration strobe. The strobe is honoured only while the buffer is empty and idle.

Top module: `dma_stream_fifo`

## Requirements
- R1: After reset the block is in buffered mode with threshold field 1 (two words) and the error enable clear, and it drives src_ready=1, dst_valid=0, err_irq=0 and done=0.
- R2: The threshold field value k (0..3) selects (k+1) words. In buffered mode, with no burst in progress and no flush pending, dst_valid stays low while fewer than that many words are stored.
- R3: When the threshold is reached, the block releases exactly the threshold number of words as one burst and then waits for the threshold again. Words accepted from the source during a burst are kept for later bursts.
- R4: With the mode bit at 0 (direct mode), dst_valid equals src_valid, dst_data equals src_data and src_ready equals dst_ready in the same cycle, and no word is stored. A mode bit of 1 selects buffered mode.
- R5: In buffered mode src_ready is low while four words are stored or a flush is pending, and high otherwise.
- R6: In buffered mode, src_valid high while four words are stored sets the error flag, and the word is not taken. err_irq is high exactly when the flag is set and the error enable is 1.
- R7: The error flag stays set until err_clr is high in a cycle with no new overrun. It then clears on that clock edge.
- R8: A flush pulse makes every stored word leave, even below the threshold, and blocks the source until the store is empty. done is high for exactly the one cycle in which a pending flush first sees an empty store. In direct mode this is the cycle after the flush pulse.
- R9: A configuration write is accepted only when no word is stored, no burst is in progress and no flush is pending. Otherwise mode, threshold and enable keep their values.
- R10: In buffered mode, words reach dst_data in the order the source delivered them, and none is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration load strobe |
| cfg_mode | input | 1 | 1 = buffered, 0 = direct |
| cfg_thresh | input | 2 | Fill threshold, (value+1) quarters of the store |
| cfg_err_en | input | 1 | Error interrupt enable |
| src_valid | input | 1 | Source word valid |
| src_ready | output | 1 | Block can take a source word |
| src_data | input | DATA_W | Source word |
| dst_valid | output | 1 | Word offered to destination |
| dst_ready | input | 1 | Destination takes the offered word |
| dst_data | output | DATA_W | Word offered to destination |
| flush | input | 1 | End-of-transfer pulse, drains leftovers |
| err_clr | input | 1 | Write-one-to-clear for the error flag |
| err_irq | output | 1 | Buffer error interrupt |
| done | output | 1 | One-cycle pulse, flush finished |

## Verification
The bench targets the cycle in which the threshold is first met. A design that waits a cycle late, or starts early at one word short, shows up as a dst_valid mismatch in that cycle. It also targets words pushed while a burst is draining: a burst counter that reloads from the live fill level would send too many words in a row. Flushing a store that holds fewer words than the threshold exposes a design that never drains leftovers or that repeats its done pulse. A configuration write landing on a non-empty buffer shows whether the design wrongly switches mode or threshold in mid-stream. Overruns with the enable clear and then set, followed by a clear, separate the sticky flag from the gated interrupt.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

   typedef enum logic {
      PATH_DIRECT   = 1'b0,
      PATH_BUFFERED = 1'b1
   } path_mode_e;

   // Words that must be stored before a burst may start, for a quarter-step selector.
   function automatic int unsigned thresh_words(input logic [1:0] sel, input int unsigned depth);
      return ((int'(sel) + 1) * depth) / 4;
   endfunction

endpackage

// File: rtl/dsf_store.sv
module dsf_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [CNT_W-1:0]  occ,
   output logic              full,
   output logic              empty
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         occ    <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   occ <= occ + 1'b1;
            2'b01:   occ <= occ - 1'b1;
            default: occ <= occ;
         endcase
      end
   end

   assign rdata = mem[rd_ptr];
   assign full  = (occ == CNT_W'(DEPTH));
   assign empty = (occ == '0);

endmodule

// File: rtl/dsf_burst_ctl.sv
module dsf_burst_ctl #(
   parameter int DEPTH = 4,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             buffered,
   input  logic [CNT_W-1:0] thr_words,
   input  logic [CNT_W-1:0] occ,
   input  logic             flush,
   input  logic             dst_ready,
   output logic             dst_vld,
   output logic             pop,
   output logic             flushing,
   output logic             done,
   output logic [CNT_W-1:0] left
);

   logic             at_thr, launch;
   logic [CNT_W-1:0] len;

   assign at_thr  = (occ >= thr_words);
   assign launch  = (left == '0) && (at_thr || (flushing && occ != '0));
   assign len     = at_thr ? thr_words : occ;
   assign dst_vld = buffered && ((left != '0) || launch);
   assign pop     = dst_vld && dst_ready;
   assign done    = flushing && (occ == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left     <= '0;
         flushing <= 1'b0;
      end else begin
         if (pop) left <= (left != '0) ? left - 1'b1 : len - 1'b1;
         if (flush)     flushing <= 1'b1;
         else if (done) flushing <= 1'b0;
      end
   end

endmodule

// File: rtl/dsf_err.sv
module dsf_err (
   input  logic clk,
   input  logic rst_n,
   input  logic overrun,
   input  logic clr,
   input  logic enable,
   output logic flag,
   output logic irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag <= 1'b0;
      else if (overrun) flag <= 1'b1;
      else if (clr)     flag <= 1'b0;
   end

   assign irq = flag && enable;

endmodule

// File: rtl/dma_stream_fifo.sv
module dma_stream_fifo #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_mode,
   input  logic [1:0]        cfg_thresh,
   input  logic              cfg_err_en,
   input  logic              src_valid,
   output logic              src_ready,
   input  logic [DATA_W-1:0] src_data,
   output logic              dst_valid,
   input  logic              dst_ready,
   output logic [DATA_W-1:0] dst_data,
   input  logic              flush,
   input  logic              err_clr,
   output logic              err_irq,
   output logic              done
);

   import dsf_pkg::*;

   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 4 || (DEPTH % 4) != 0) begin : g_bad_depth
         $error("dma_stream_fifo: DEPTH must be a positive multiple of 4");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("dma_stream_fifo: DATA_W must be at least 1");
      end
   endgenerate

   path_mode_e        mode_q;
   logic [1:0]        thr_q;
   logic              ie_q;
   logic [CNT_W-1:0]  thr_words, occ, left_q;
   logic              buffered, full, empty, flushing;
   logic              push, pop, dst_vld_b, overrun, cfg_take, err_flag;
   logic [DATA_W-1:0] rdata;

   assign buffered  = (mode_q == PATH_BUFFERED);
   assign thr_words = CNT_W'(thresh_words(thr_q, DEPTH));
   assign cfg_take  = cfg_wr && empty && (left_q == '0) && !flushing;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= PATH_BUFFERED;
         thr_q  <= 2'd1;
         ie_q   <= 1'b0;
      end else if (cfg_take) begin
         mode_q <= path_mode_e'(cfg_mode);
         thr_q  <= cfg_thresh;
         ie_q   <= cfg_err_en;
      end
   end

   assign src_ready = buffered ? (!full && !flushing) : dst_ready;
   assign push      = buffered && src_valid && src_ready;
   assign overrun   = buffered && src_valid && full;
   assign dst_valid = buffered ? dst_vld_b : src_valid;
   assign dst_data  = buffered ? rdata : src_data;

   dsf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .pop   (pop),
      .wdata (src_data),
      .rdata (rdata),
      .occ   (occ),
      .full  (full),
      .empty (empty)
   );

   dsf_burst_ctl #(.DEPTH(DEPTH)) burst_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .buffered  (buffered),
      .thr_words (thr_words),
      .occ       (occ),
      .flush     (flush),
      .dst_ready (dst_ready),
      .dst_vld   (dst_vld_b),
      .pop       (pop),
      .flushing  (flushing),
      .done      (done),
      .left      (left_q)
   );

   dsf_err err_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .overrun (overrun),
      .clr     (err_clr),
      .enable  (ie_q),
      .flag    (err_flag),
      .irq     (err_irq)
   );

endmodule

// File: rtl/dsf_checker.sv
module dsf_checker #(
   parameter int DEPTH = 4,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             buffered,
   input logic [1:0]       thr_q,
   input logic             ie_q,
   input logic [CNT_W-1:0] thr_words,
   input logic [CNT_W-1:0] occ,
   input logic [CNT_W-1:0] left_q,
   input logic             flushing,
   input logic             cfg_wr,
   input logic             src_valid,
   input logic             src_ready,
   input logic             dst_valid,
   input logic             dst_ready,
   input logic             err_flag,
   input logic             err_clr,
   input logic             err_irq,
   input logic             done
);

   p_wait_thr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (buffered && left_q == '0 && !flushing && occ < thr_words) |-> !dst_valid)
      else $error("R2: destination offered a word below threshold");

   p_burst_in_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
      left_q <= occ)
      else $error("R3: burst remainder exceeds stored words");

   p_direct_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !buffered |-> (dst_valid == src_valid) && (src_ready == dst_ready) && (occ == '0))
      else $error("R4: direct path not transparent");

   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (buffered && occ == CNT_W'(DEPTH)) |-> !src_ready)
      else $error("R5: source accepted while full");

   p_overrun_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (buffered && src_valid && occ == CNT_W'(DEPTH)) |=> err_flag)
      else $error("R6: overrun not flagged");

   p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ie_q |-> !err_irq)
      else $error("R6: interrupt while disabled");

   p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !err_clr) |=> err_flag)
      else $error("R7: error flag dropped without clear");

   p_done_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (occ == '0))
      else $error("R8: done with words still stored");

   p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && occ != '0) |=> ($stable(buffered) && $stable(thr_q) && $stable(ie_q)))
      else $error("R9: configuration changed while busy");

   p_ready_dst_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (buffered && dst_valid && !dst_ready) |=> dst_valid)
      else $error("R10: offered word withdrawn");

endmodule

bind dma_stream_fifo dsf_checker #(.DEPTH(DEPTH)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .buffered  (buffered),
   .thr_q     (thr_q),
   .ie_q      (ie_q),
   .thr_words (thr_words),
   .occ       (occ),
   .left_q    (left_q),
   .flushing  (flushing),
   .cfg_wr    (cfg_wr),
   .src_valid (src_valid),
   .src_ready (src_ready),
   .dst_valid (dst_valid),
   .dst_ready (dst_ready),
   .err_flag  (err_flag),
   .err_clr   (err_clr),
   .err_irq   (err_irq),
   .done      (done)
);

// File: tb/dma_stream_fifo_tb_top.sv
module dma_stream_fifo_tb_top;

   localparam int DW  = 16;
   localparam int DEP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0, cfg_mode = 1'b1, cfg_err_en = 1'b0;
   logic [1:0]    cfg_thresh = 2'd0;
   logic          src_valid = 1'b0, dst_ready = 1'b0, flush = 1'b0, err_clr = 1'b0;
   logic [DW-1:0] src_data = '0;
   logic          src_ready, dst_valid, err_irq, done;
   logic [DW-1:0] dst_data;

   always #5 clk = ~clk;

   dma_stream_fifo #(.DATA_W(DW), .DEPTH(DEP)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wr     (cfg_wr),
      .cfg_mode   (cfg_mode),
      .cfg_thresh (cfg_thresh),
      .cfg_err_en (cfg_err_en),
      .src_valid  (src_valid),
      .src_ready  (src_ready),
      .src_data   (src_data),
      .dst_valid  (dst_valid),
      .dst_ready  (dst_ready),
      .dst_data   (dst_data),
      .flush      (flush),
      .err_clr    (err_clr),
      .err_irq    (err_irq),
      .done       (done)
   );

   int        n_chk = 0, n_fail = 0;
   string     tag = "R1";
   bit        finished = 1'b0;
   bit        last_push;
   logic [15:0] lfsr = 16'hACE1;

   // reference model state
   logic [DW-1:0] q[$];
   int  m_left = 0, m_thr = 2;
   bit  m_mode = 1'b1, m_ie = 1'b0, m_err = 1'b0, m_flush = 1'b0;

   task automatic chk(string t, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
      end
   endtask

   task automatic tick();
      int sz, len;
      bit full_m, launch, e_srdy, e_dvld, e_done, e_irq, acc, ovr;
      logic [DW-1:0] e_data;
      #1;
      sz     = q.size();
      full_m = (sz == DEP);
      launch = (m_left == 0) && ((sz >= m_thr) || (m_flush && sz > 0));
      len    = (sz >= m_thr) ? m_thr : sz;
      e_srdy = m_mode ? (!full_m && !m_flush) : dst_ready;
      e_dvld = m_mode ? ((m_left != 0) || launch) : src_valid;
      e_data = m_mode ? ((sz > 0) ? q[0] : '0) : src_data;
      e_done = m_flush && (sz == 0);
      e_irq  = m_err && m_ie;
      chk(tag, "src_ready", 32'(src_ready), 32'(e_srdy));
      chk(tag, "dst_valid", 32'(dst_valid), 32'(e_dvld));
      chk(tag, "err_irq",   32'(err_irq),   32'(e_irq));
      chk(tag, "done",      32'(done),      32'(e_done));
      if (e_dvld) chk(tag, "dst_data", 32'(dst_data), 32'(e_data));
      acc = cfg_wr && (sz == 0) && (m_left == 0) && !m_flush;
      ovr = m_mode && src_valid && full_m;
      @(posedge clk);
      if (m_mode && e_dvld && dst_ready) begin
         void'(q.pop_front());
         if (m_left != 0) m_left--;
         else m_left = len - 1;
      end
      last_push = m_mode ? (src_valid && e_srdy) : (src_valid && dst_ready);
      if (m_mode && src_valid && e_srdy) q.push_back(src_data);
      if (ovr) m_err = 1'b1;
      else if (err_clr) m_err = 1'b0;
      if (flush) m_flush = 1'b1;
      else if (e_done) m_flush = 1'b0;
      if (acc) begin
         m_mode = cfg_mode;
         m_thr  = (int'(cfg_thresh) + 1) * DEP / 4;
         m_ie   = cfg_err_en;
      end
      @(negedge clk);
   endtask

   task automatic lfsr_step();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   task automatic do_cfg(bit md, logic [1:0] th, bit ie);
      cfg_wr = 1'b1; cfg_mode = md; cfg_thresh = th; cfg_err_en = ie;
      tick();
      cfg_wr = 1'b0;
   endtask

   task automatic drain();
      src_valid = 1'b0;
      flush = 1'b1; tick(); flush = 1'b0;
      dst_ready = 1'b1;
      for (int i = 0; i < 8; i++) tick();
   endtask

   task automatic traffic(int cycles, int vmask, int rmask);
      for (int i = 0; i < cycles; i++) begin
         lfsr_step();
         src_valid = ((lfsr[3:0] & 4'(vmask)) != 0);
         dst_ready = ((lfsr[7:4] & 4'(rmask)) != 0);
         tick();
         if (last_push) src_data = src_data + 1'b1;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      tag = "R1"; tick();

      // R2: threshold of two words, nothing offered with one stored
      tag = "R2"; dst_ready = 1'b1;
      src_valid = 1'b1; src_data = 16'h0100; tick();
      src_valid = 1'b0; tick(); tick();
      // R3: second word completes the burst
      tag = "R3"; src_valid = 1'b1; src_data = 16'h0101; tick();
      src_valid = 1'b0; tick(); tick(); tick();

      // R3 / R10: every threshold under mixed traffic
      for (int t = 0; t < 4; t++) begin
         tag = "R3"; drain(); do_cfg(1'b1, 2'(t), 1'b0);
         tag = "R10"; traffic(60, 4'b0111, 4'b0011);
      end

      // R5: fill with destination stalled at full threshold
      tag = "R5"; drain(); do_cfg(1'b1, 2'd3, 1'b0);
      dst_ready = 1'b0;
      for (int i = 0; i < 4; i++) begin src_valid = 1'b1; src_data = 16'h0500 + 16'(i); tick(); end
      // R6: overrun with enable clear: flag set, no interrupt
      tag = "R6"; src_valid = 1'b1; tick(); src_valid = 1'b0; tick();

      // R9: config write while words are stored is ignored
      tag = "R9"; dst_ready = 1'b1; tick(); tick(); tick(); tick();
      dst_ready = 1'b0; src_valid = 1'b1; tick(); src_valid = 1'b0;
      do_cfg(1'b0, 2'd0, 1'b1);
      tick(); tick();
      src_valid = 1'b1; tick(); tick(); src_valid = 1'b0; tick();

      // R7: clear the flag, then R6 with enable set
      tag = "R7"; drain(); err_clr = 1'b1; tick(); err_clr = 1'b0; tick();
      do_cfg(1'b1, 2'd0, 1'b1);
      tag = "R6"; dst_ready = 1'b0;
      for (int i = 0; i < 5; i++) begin src_valid = 1'b1; src_data = 16'h0600 + 16'(i); tick(); end
      src_valid = 1'b0;
      tag = "R7"; tick(); tick(); tick();
      err_clr = 1'b1; tick(); err_clr = 1'b0; tick();

      // R8: flush words below the threshold
      tag = "R8"; drain(); do_cfg(1'b1, 2'd3, 1'b0);
      dst_ready = 1'b1;
      src_valid = 1'b1; src_data = 16'h0800; tick(); src_data = 16'h0801; tick();
      src_valid = 1'b0; tick(); tick();
      flush = 1'b1; tick(); flush = 1'b0;
      src_valid = 1'b1; src_data = 16'h0802; tick(); src_valid = 1'b0;
      for (int i = 0; i < 5; i++) tick();

      // R4: direct mode pass-through, then flush in direct mode
      tag = "R4"; do_cfg(1'b0, 2'd2, 1'b0);
      traffic(40, 4'b0101, 4'b0110);
      tag = "R8"; src_valid = 1'b0; flush = 1'b1; tick(); flush = 1'b0; tick(); tick();

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog run did not finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule